// File: doc/BRIEF.md
# Second-Stage Table Walker with Access/Dirty Tracking

This block walks the second-stage translation tables of a DMA remapping unit for one request at a time. A request carries an I/O virtual address, a direction (read or write), the physical base of the top table, the level at which the walk starts and a tracking enable. The tracking enable is bit 9 of the context's table-entry flags, and the surrounding logic passes it in on its own pin. The walker fetches one 64-bit entry per level through a single memory port. Along the way it narrows the read and write rights. It stops at the first leaf and returns that leaf, the leaf's level and the rights that survived. If something goes wrong it returns a fault code instead.

When tracking is enabled, the walker marks the leaf as accessed and, for a write, as dirty. It builds the new leaf value in a register and writes it back only if a flag actually changed. It then reads the entry again and reports the value that memory returns. The translation cache, the invalidation machinery and the first-stage tables are the neighbours' concern.

Top module: `ssw_walker`

## Requirements
- R1: `req_ready` is high only while the walker is idle. After reset it is high, and `rsp_valid` and `mem_req_valid` are low. A request is taken only when `req_valid` and `req_ready` are both high. Each finished walk gives exactly one single-cycle `rsp_valid` pulse, and the walker then becomes idle again.
- R2: A request is refused with fault code 1 and no memory access in either of two cases: an address bit at position `req_aw` or above is set, or the starting level is 0 or above `MAX_LVL`.
- R3: At level L the entry is read from address `(base & ~0xFFF) + 8 * iova[12+9*(L-1) +: 9]`. The base for the next level down is the entry's bits `[PA_W-1:12]` with the low 12 bits set to zero.
- R4: `rsp_read_ok` is the AND of bit 0 of every entry fetched on the path. `rsp_write_ok` is the AND of bit 1 of those entries.
- R5: An entry is a leaf when it is fetched at level 1, or when its bit 7 is set at any higher level. A successful walk reports fault code 0, the leaf's level and the leaf entry.
- R6: When `req_ad_en` is low, the walker issues no memory write, and the reported entry equals the stored leaf.
- R7: With tracking on, a write request whose accumulated write right is granted sets bit 9 (dirty) of the leaf if that bit is clear.
- R8: With tracking on, bit 8 (accessed) of the leaf is set if it is clear and either of two things holds: the request is a read with the accumulated read right granted, or the dirty bit was set by this same request.
- R9: The leaf is written back only if at least one flag changed. After the write the leaf is read again, and the value returned by that read is reported as the result.
- R10: An error response on a fetch, a write-back or a re-read ends the walk. The fault code is 2 if the failing level equals the starting level, and 3 otherwise. `rsp_level` gives the failing level.
- R11: `mem_req_valid`, `mem_req_we` and `mem_req_addr` stay stable until `mem_req_ready` is seen. No new memory request is raised while a response is still outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_iova | input | IOVA_W | I/O virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_root | input | PA_W | Physical base of the starting table |
| req_level | input | LVL_W | Starting level (1..MAX_LVL) |
| req_aw | input | AW_W | Configured address width in bits |
| req_ad_en | input | 1 | Access/dirty tracking enable (context flags bit 9) |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | PA_W | Byte address of the 64-bit entry |
| mem_req_wdata | output | 64 | Write data |
| mem_rsp_valid | input | 1 | Memory response present |
| mem_rsp_err | input | 1 | Memory response carries an error |
| mem_rsp_rdata | input | 64 | Read data |
| rsp_valid | output | 1 | Walk result valid (one cycle) |
| rsp_fault | output | 2 | 0 none, 1 address overflow, 2 context entry invalid, 3 paging entry invalid |
| rsp_entry | output | 64 | Final leaf entry |
| rsp_level | output | LVL_W | Leaf level or failing level |
| rsp_read_ok | output | 1 | Accumulated read right |
| rsp_write_ok | output | 1 | Accumulated write right |

## Verification
A single access can set the dirty flag and the accessed flag at once. This happens for a write with the write right granted to a leaf that has both flags clear, because setting the dirty flag is itself a reason to set the accessed flag. The sweep reaches this case by combining every starting-flag pattern with every permission pattern and both directions. The bench then checks that exactly one memory write occurred and that both bits appear in the reported value and in the stored leaf. Fault codes are checked at the same time with error injection: the same faulting entry is reported as context-invalid or paging-invalid depending on whether its level matches the starting level.

// File: rtl/ssw_pkg.sv
package ssw_pkg;

    localparam int ENT_W    = 64;
    localparam int PG_SHIFT = 12;
    localparam int IDX_W    = 9;

    localparam int BIT_R  = 0;
    localparam int BIT_W  = 1;
    localparam int BIT_PS = 7;
    localparam int BIT_A  = 8;
    localparam int BIT_D  = 9;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_RANGE = 2'd1,
        FLT_CTX   = 2'd2,
        FLT_PAGE  = 2'd3
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WB_REQ,
        ST_WB_WAIT,
        ST_RR_REQ,
        ST_RR_WAIT,
        ST_DONE
    } wstate_e;

    typedef struct packed {
        logic [ENT_W-1:0] entry;
        logic             changed;
    } ad_upd_t;

    function automatic logic is_leaf(input logic ps_bit, input logic at_bottom);
        return at_bottom | ps_bit;
    endfunction

    function automatic fault_e fault_for(input logic [7:0] lvl, input logic [7:0] start);
        return (lvl == start) ? FLT_CTX : FLT_PAGE;
    endfunction

endpackage

// File: rtl/ssw_range_chk.sv
module ssw_range_chk #(
    parameter int IOVA_W  = 48,
    parameter int AW_W    = 6,
    parameter int MAX_LVL = 4,
    parameter int LVL_W   = 3
) (
    input  logic [IOVA_W-1:0] iova,
    input  logic [AW_W-1:0]   aw,
    input  logic [LVL_W-1:0]  level,
    output logic              reject
);
    logic above;
    logic lvl_bad;

    always_comb begin
        above = 1'b0;
        for (int i = 0; i < IOVA_W; i++) begin
            if (iova[i] && (32'(i) >= 32'(aw)))
                above = 1'b1;
        end
    end

    assign lvl_bad = (level == '0) || (32'(level) > MAX_LVL);
    assign reject  = above | lvl_bad;

endmodule

// File: rtl/ssw_index.sv
module ssw_index #(
    parameter int IOVA_W  = 48,
    parameter int PA_W    = 48,
    parameter int MAX_LVL = 4,
    parameter int LVL_W   = 3
) (
    input  logic [PA_W-1:0]   base,
    input  logic [IOVA_W-13:0] vpn,
    input  logic [LVL_W-1:0]  level,
    output logic [PA_W-1:0]   addr
);
    import ssw_pkg::*;

    localparam int VPN_W = IOVA_W - PG_SHIFT;

    logic [IDX_W-1:0] idx_at [MAX_LVL+1];
    logic [IDX_W-1:0] sel;

    assign idx_at[0] = '0;

    for (genvar g = 1; g <= MAX_LVL; g++) begin : g_lvl
        localparam int LO = IDX_W * (g - 1);
        if (LO + IDX_W <= VPN_W) begin : g_full
            assign idx_at[g] = vpn[LO +: IDX_W];
        end else if (LO < VPN_W) begin : g_part
            assign idx_at[g] = IDX_W'(vpn[VPN_W-1:LO]);
        end else begin : g_none
            assign idx_at[g] = '0;
        end
    end

    always_comb begin
        sel = '0;
        for (int i = 1; i <= MAX_LVL; i++) begin
            if (level == LVL_W'(i))
                sel = idx_at[i];
        end
    end

    assign addr = {base[PA_W-1:PG_SHIFT], sel, 3'b000};

endmodule

// File: rtl/ssw_ad_logic.sv
module ssw_ad_logic (
    input  logic [63:0]       entry_in,
    input  logic              ad_en,
    input  logic              is_write,
    input  logic              rd_ok,
    input  logic              wr_ok,
    output ssw_pkg::ad_upd_t  upd
);
    import ssw_pkg::*;

    logic mark_d;
    logic mark_a;

    assign mark_d = ad_en & is_write & wr_ok & ~entry_in[BIT_D];
    assign mark_a = ad_en & ~entry_in[BIT_A] & ((~is_write & rd_ok) | mark_d);

    always_comb begin
        upd.entry        = entry_in;
        upd.entry[BIT_D] = entry_in[BIT_D] | mark_d;
        upd.entry[BIT_A] = entry_in[BIT_A] | mark_a;
        upd.changed      = mark_d | mark_a;
    end

endmodule

// File: rtl/ssw_walker.sv
module ssw_walker #(
    parameter int IOVA_W  = 48,
    parameter int PA_W    = 48,
    parameter int MAX_LVL = 4,
    parameter int LVL_W   = $clog2(MAX_LVL + 1),
    parameter int AW_W    = $clog2(IOVA_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [IOVA_W-1:0] req_iova,
    input  logic              req_write,
    input  logic [PA_W-1:0]   req_root,
    input  logic [LVL_W-1:0]  req_level,
    input  logic [AW_W-1:0]   req_aw,
    input  logic              req_ad_en,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_we,
    output logic [PA_W-1:0]   mem_req_addr,
    output logic [63:0]       mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic              mem_rsp_err,
    input  logic [63:0]       mem_rsp_rdata,
    output logic              rsp_valid,
    output logic [1:0]        rsp_fault,
    output logic [63:0]       rsp_entry,
    output logic [LVL_W-1:0]  rsp_level,
    output logic              rsp_read_ok,
    output logic              rsp_write_ok
);
    import ssw_pkg::*;

    localparam int VPN_W = IOVA_W - PG_SHIFT;

    wstate_e            state;
    logic [VPN_W-1:0]   cur_vpn;
    logic               cur_write;
    logic               cur_ad;
    logic [LVL_W-1:0]   start_lvl;
    logic [LVL_W-1:0]   cur_lvl;
    logic [PA_W-1:0]    cur_base;
    logic [PA_W-1:0]    leaf_addr;
    logic [63:0]        leaf_entry;
    logic [63:0]        out_entry;
    logic               rd_acc;
    logic               wr_acc;
    fault_e             flt_q;

    logic               reject;
    logic [PA_W-1:0]    idx_addr;
    logic               rd_next;
    logic               wr_next;
    logic               leaf_hit;
    logic [PA_W-1:0]    next_base;
    ad_upd_t            upd;

    ssw_range_chk #(
        .IOVA_W (IOVA_W),
        .AW_W   (AW_W),
        .MAX_LVL(MAX_LVL),
        .LVL_W  (LVL_W)
    ) u_range (
        .iova  (req_iova),
        .aw    (req_aw),
        .level (req_level),
        .reject(reject)
    );

    ssw_index #(
        .IOVA_W (IOVA_W),
        .PA_W   (PA_W),
        .MAX_LVL(MAX_LVL),
        .LVL_W  (LVL_W)
    ) u_index (
        .base (cur_base),
        .vpn  (cur_vpn),
        .level(cur_lvl),
        .addr (idx_addr)
    );

    assign rd_next   = rd_acc & mem_rsp_rdata[BIT_R];
    assign wr_next   = wr_acc & mem_rsp_rdata[BIT_W];
    assign leaf_hit  = is_leaf(mem_rsp_rdata[BIT_PS], cur_lvl == LVL_W'(1));
    assign next_base = {mem_rsp_rdata[PA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}};

    ssw_ad_logic u_ad (
        .entry_in(mem_rsp_rdata),
        .ad_en   (cur_ad),
        .is_write(cur_write),
        .rd_ok   (rd_next),
        .wr_ok   (wr_next),
        .upd     (upd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cur_vpn    <= '0;
            cur_write  <= 1'b0;
            cur_ad     <= 1'b0;
            start_lvl  <= '0;
            cur_lvl    <= '0;
            cur_base   <= '0;
            leaf_addr  <= '0;
            leaf_entry <= '0;
            out_entry  <= '0;
            rd_acc     <= 1'b0;
            wr_acc     <= 1'b0;
            flt_q      <= FLT_NONE;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        cur_vpn   <= req_iova[IOVA_W-1:PG_SHIFT];
                        cur_write <= req_write;
                        cur_ad    <= req_ad_en;
                        start_lvl <= req_level;
                        cur_lvl   <= req_level;
                        cur_base  <= req_root;
                        rd_acc    <= 1'b1;
                        wr_acc    <= 1'b1;
                        out_entry <= '0;
                        if (reject) begin
                            flt_q <= FLT_RANGE;
                            state <= ST_DONE;
                        end else begin
                            flt_q <= FLT_NONE;
                            state <= ST_RD_REQ;
                        end
                    end
                end
                ST_RD_REQ: begin
                    if (mem_req_ready) begin
                        leaf_addr <= idx_addr;
                        state     <= ST_RD_WAIT;
                    end
                end
                ST_RD_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (mem_rsp_err) begin
                            flt_q <= fault_for(8'(cur_lvl), 8'(start_lvl));
                            state <= ST_DONE;
                        end else begin
                            rd_acc <= rd_next;
                            wr_acc <= wr_next;
                            if (leaf_hit) begin
                                if (upd.changed) begin
                                    leaf_entry <= upd.entry;
                                    state      <= ST_WB_REQ;
                                end else begin
                                    out_entry <= mem_rsp_rdata;
                                    state     <= ST_DONE;
                                end
                            end else begin
                                cur_base <= next_base;
                                cur_lvl  <= cur_lvl - LVL_W'(1);
                                state    <= ST_RD_REQ;
                            end
                        end
                    end
                end
                ST_WB_REQ: begin
                    if (mem_req_ready)
                        state <= ST_WB_WAIT;
                end
                ST_WB_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (mem_rsp_err) begin
                            flt_q <= fault_for(8'(cur_lvl), 8'(start_lvl));
                            state <= ST_DONE;
                        end else begin
                            state <= ST_RR_REQ;
                        end
                    end
                end
                ST_RR_REQ: begin
                    if (mem_req_ready)
                        state <= ST_RR_WAIT;
                end
                ST_RR_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (mem_rsp_err) begin
                            flt_q <= fault_for(8'(cur_lvl), 8'(start_lvl));
                        end else begin
                            out_entry <= mem_rsp_rdata;
                        end
                        state <= ST_DONE;
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready     = (state == ST_IDLE);
    assign mem_req_valid = (state == ST_RD_REQ) || (state == ST_WB_REQ) || (state == ST_RR_REQ);
    assign mem_req_we    = (state == ST_WB_REQ);
    assign mem_req_addr  = (state == ST_RD_REQ) ? idx_addr : leaf_addr;
    assign mem_req_wdata = leaf_entry;

    assign rsp_valid    = (state == ST_DONE);
    assign rsp_fault    = flt_q;
    assign rsp_entry    = out_entry;
    assign rsp_level    = cur_lvl;
    assign rsp_read_ok  = rd_acc;
    assign rsp_write_ok = wr_acc;

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=>
            mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we));

    // R11
    one_out_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rsp_valid |-> !mem_req_valid);

    // R6
    no_wb_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && mem_req_we |-> cur_ad);

    // R8
    wb_acc_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && mem_req_we |-> mem_req_wdata[BIT_A]);

    // R1
    busy_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid && req_ready);

endmodule

// File: tb/sim_ssw_walker.sv
module sim_ssw_walker;

    localparam int CLK_PERIOD = 10;
    localparam int IOVA_W  = 48;
    localparam int PA_W    = 48;
    localparam int MAX_LVL = 4;
    localparam int LVL_W   = 3;
    localparam int AW_W    = 6;
    localparam logic [63:0] MARK    = 64'h1 << 52;
    localparam logic [47:0] LEAF_PA = 48'h00AB_CDEF_0000;
    localparam logic [47:0] VA_SEED = 48'h7A5C_3E91_B2F4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [IOVA_W-1:0] req_iova = '0;
    logic              req_write = 1'b0;
    logic [PA_W-1:0]   req_root = '0;
    logic [LVL_W-1:0]  req_level = '0;
    logic [AW_W-1:0]   req_aw = '0;
    logic              req_ad_en = 1'b0;
    logic              mem_req_valid;
    logic              mem_req_ready;
    logic              mem_req_we;
    logic [PA_W-1:0]   mem_req_addr;
    logic [63:0]       mem_req_wdata;
    logic              mem_rsp_valid;
    logic              mem_rsp_err;
    logic [63:0]       mem_rsp_rdata;
    logic              rsp_valid;
    logic [1:0]        rsp_fault;
    logic [63:0]       rsp_entry;
    logic [LVL_W-1:0]  rsp_level;
    logic              rsp_read_ok;
    logic              rsp_write_ok;

    int vecs = 0;
    int fails = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    int overlap_cnt = 0;
    int stall = 0;

    logic [63:0] mem [logic [47:0]];
    logic        err_on = 1'b0;
    logic        err_we = 1'b0;
    logic [47:0] err_addr = '0;
    logic        hit;

    logic [63:0] leaf_val;
    logic [47:0] leaf_at;
    logic [1:0]  got_fault;
    logic [63:0] got_entry;
    logic [2:0]  got_level;
    logic        got_rok;
    logic        got_wok;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ssw_walker #(
        .IOVA_W (IOVA_W),
        .PA_W   (PA_W),
        .MAX_LVL(MAX_LVL)
    ) u0 (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_iova     (req_iova),
        .req_write    (req_write),
        .req_root     (req_root),
        .req_level    (req_level),
        .req_aw       (req_aw),
        .req_ad_en    (req_ad_en),
        .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready),
        .mem_req_we   (mem_req_we),
        .mem_req_addr (mem_req_addr),
        .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_err  (mem_rsp_err),
        .mem_rsp_rdata(mem_rsp_rdata),
        .rsp_valid    (rsp_valid),
        .rsp_fault    (rsp_fault),
        .rsp_entry    (rsp_entry),
        .rsp_level    (rsp_level),
        .rsp_read_ok  (rsp_read_ok),
        .rsp_write_ok (rsp_write_ok)
    );

    // memory model: response one cycle after acceptance, ready stalls every third cycle
    always @(posedge clk) begin
        if (rst) begin
            mem_req_ready <= 1'b0;
            mem_rsp_valid <= 1'b0;
            mem_rsp_err   <= 1'b0;
            mem_rsp_rdata <= '0;
            stall         <= 0;
        end else begin
            stall         <= stall + 1;
            mem_req_ready <= (stall % 3) != 2;
            mem_rsp_valid <= 1'b0;
            mem_rsp_err   <= 1'b0;
            if (mem_req_valid && mem_rsp_valid)
                overlap_cnt++;
            if (mem_req_valid && mem_req_ready) begin
                hit = err_on && (mem_req_addr == err_addr) && (mem_req_we == err_we);
                mem_rsp_valid <= 1'b1;
                mem_rsp_err   <= hit;
                if (mem_req_we) begin
                    wr_cnt++;
                    if (!hit)
                        mem[mem_req_addr] = mem_req_wdata | MARK;
                    mem_rsp_rdata <= '0;
                end else begin
                    rd_cnt++;
                    mem_rsp_rdata <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 64'h0;
                end
            end
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        vecs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [47:0] tb_base(input int l);
        return 48'h10000 + 48'(l) * 48'h1000;
    endfunction

    function automatic logic [8:0] ix(input logic [47:0] v, input int l);
        return v[12 + 9 * (l - 1) +: 9];
    endfunction

    function automatic logic [47:0] va_mask(input int bits);
        logic [47:0] m = '0;
        for (int i = 0; i < 48; i++)
            if (i < bits) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [47:0] ent_addr(input int l, input logic [47:0] v);
        return tb_base(l) + {36'd0, ix(v, l), 3'b000};
    endfunction

    task automatic build(input int sl, input int ll, input logic [1:0] up,
                         input logic [1:0] lf, input logic [1:0] ad, input logic [47:0] va);
        mem.delete();
        for (int l = sl; l > ll; l--)
            mem[ent_addr(l, va)] = {16'h0, tb_base(l - 1)} | {62'd0, up};
        leaf_val = {16'h0, LEAF_PA} | {62'd0, lf} | ((ll > 1) ? 64'h80 : 64'h0) | {54'd0, ad, 8'd0};
        leaf_at  = ent_addr(ll, va);
        mem[leaf_at] = leaf_val;
    endtask

    task automatic walk(input logic [47:0] va, input logic wr, input int sl,
                        input logic [5:0] aw, input logic en);
        int waited;
        @(negedge clk);
        req_valid = 1'b1;
        req_iova  = va;
        req_write = wr;
        req_root  = tb_base(sl);
        req_level = 3'(sl);
        req_aw    = aw;
        req_ad_en = en;
        @(negedge clk);
        req_valid = 1'b0;
        // R1: busy once a request is taken
        chk("R1", "ready during walk", {63'd0, req_ready}, 64'd0);
        waited = 0;
        while (!rsp_valid && waited < 400) begin
            @(negedge clk);
            waited++;
        end
        if (!rsp_valid)
            chk("R11", "walk response missing", 64'd0, 64'd1);
        got_fault = rsp_fault;
        got_entry = rsp_entry;
        got_level = rsp_level;
        got_rok   = rsp_read_ok;
        got_wok   = rsp_write_ok;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog: actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        logic [47:0] va;
        int          r0;
        int          w0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "ready after reset", {63'd0, req_ready}, 64'd1);
        chk("R1", "rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
        chk("R11", "mem_req_valid after reset", {63'd0, mem_req_valid}, 64'd0);

        // R2: address above configured width
        build(3, 1, 2'b11, 2'b11, 2'b00, VA_SEED & va_mask(39));
        r0 = rd_cnt;
        walk((VA_SEED & va_mask(39)) | (48'h1 << 40), 1'b0, 3, 6'd39, 1'b1);
        chk("R2", "overflow fault", 64'(got_fault), 64'd1);
        chk("R2", "no fetch on overflow", 64'(rd_cnt - r0), 64'd0);
        chk("R1", "ready after fault", {63'd0, req_ready}, 64'd1);
        // R2: bit exactly at width limit
        walk((VA_SEED & va_mask(30)) | (48'h1 << 30), 1'b0, 2, 6'd30, 1'b0);
        chk("R2", "boundary bit fault", 64'(got_fault), 64'd1);
        // R2: starting level 0
        walk(48'h0, 1'b0, 0, 6'd48, 1'b0);
        chk("R2", "level zero fault", 64'(got_fault), 64'd1);

        // R10: fetch error at starting level
        va = VA_SEED & va_mask(39);
        build(3, 1, 2'b11, 2'b11, 2'b00, va);
        err_on = 1'b1; err_we = 1'b0; err_addr = ent_addr(3, va);
        walk(va, 1'b0, 3, 6'd39, 1'b1);
        chk("R10", "fetch error at start level", 64'(got_fault), 64'd2);
        chk("R10", "failing level", 64'(got_level), 64'd3);
        // R10: fetch error at lower level
        err_addr = ent_addr(2, va);
        walk(va, 1'b0, 3, 6'd39, 1'b1);
        chk("R10", "fetch error below start", 64'(got_fault), 64'd3);
        chk("R10", "failing level low", 64'(got_level), 64'd2);
        // R10: write-back error with leaf at starting level
        va = VA_SEED & va_mask(30);
        build(2, 2, 2'b11, 2'b11, 2'b00, va);
        err_we = 1'b1; err_addr = ent_addr(2, va);
        walk(va, 1'b1, 2, 6'd30, 1'b1);
        chk("R10", "write-back error at start level", 64'(got_fault), 64'd2);
        // R10: write-back error below start
        va = VA_SEED & va_mask(39);
        build(3, 1, 2'b11, 2'b11, 2'b00, va);
        err_addr = ent_addr(1, va);
        walk(va, 1'b1, 3, 6'd39, 1'b1);
        chk("R10", "write-back error below start", 64'(got_fault), 64'd3);
        err_on = 1'b0;

        // sweep of depth, leaf level, rights, direction, enable and flag state
        for (int sl = 1; sl <= MAX_LVL; sl++) begin
            for (int ll = 1; ll <= sl; ll++) begin
                for (int up = 0; up < 4; up++) begin
                    for (int lf = 0; lf < 4; lf++) begin
                        for (int wr = 0; wr < 2; wr++) begin
                            for (int en = 0; en < 2; en++) begin
                                for (int ad = 0; ad < 4; ad++) begin
                                    logic        rok, wok, sd, sa, chg;
                                    logic [63:0] exp_e;
                                    va = VA_SEED & va_mask(12 + 9 * sl);
                                    build(sl, ll, 2'(up), 2'(lf), 2'(ad), va);
                                    rok = lf[0] & ((ll < sl) ? up[0] : 1'b1);
                                    wok = lf[1] & ((ll < sl) ? up[1] : 1'b1);
                                    sd  = (en == 1) && (wr == 1) && wok && !ad[1];
                                    sa  = (en == 1) && !ad[0] && (((wr == 0) && rok) || sd);
                                    chg = sd | sa;
                                    exp_e = leaf_val | (sd ? 64'h200 : 64'h0) | (sa ? 64'h100 : 64'h0)
                                            | (chg ? MARK : 64'h0);
                                    w0 = wr_cnt;
                                    walk(va, wr[0], sl, 6'(12 + 9 * sl), en[0]);
                                    chk("R5", "fault code", 64'(got_fault), 64'd0);
                                    chk("R5", "leaf level", 64'(got_level), 64'(ll));
                                    chk("R4", "rights", {62'd0, got_rok, got_wok}, {62'd0, rok, wok});
                                    chk("R3", "leaf address field", {16'd0, got_entry[47:12], 12'd0},
                                        {16'd0, LEAF_PA});
                                    chk("R7", "dirty bit", {63'd0, got_entry[9]}, {63'd0, ad[1] | sd});
                                    chk("R8", "accessed bit", {63'd0, got_entry[8]}, {63'd0, ad[0] | sa});
                                    chk("R9", "reported entry", got_entry, exp_e);
                                    chk("R9", "write-back count", 64'(wr_cnt - w0), {63'd0, chg});
                                    chk("R9", "stored leaf", mem[leaf_at], exp_e);
                                    if (en == 0)
                                        chk("R6", "disabled entry untouched", got_entry, leaf_val);
                                end
                            end
                        end
                    end
                end
            end
        end

        // R11: no request raised while a response was pending
        chk("R11", "overlapping requests", 64'(overlap_cnt), 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

endmodule